// File: doc/BRIEF.md
# Context Admin Queue Engine

This block executes management commands that software places in a ring of fixed-size instructions in memory. Each instruction targets one context entry, chosen by a context type, a logical-function number and an index, and kept in a small local context store. The supported operations are initialize, masked write, read, lock and unlock. A no-op is also accepted. For every instruction the engine writes a result record back to memory. The record carries a completion code, and for a read it also carries the context contents.

Software sets the ring base and the ring size, then reports new work by pulsing a doorbell with a count. The engine fetches the slots in ring order, runs each one to completion, writes the result, and moves to the next slot. The read pointer wraps at the programmed size. All memory traffic uses one request/grant port with 64-bit words. Only one read is in flight at a time. A configuration input makes the engine byte-swap every word it moves.

Top module: `ctx_aq_engine`

## Requirements
- R1: Instruction n is fetched as two words, at cfg_base + 16*ptr (word 0) and at +8 (word 1, the result address). ptr starts at 0 after reset, advances by one per instruction, and wraps to 0 at cfg_size. In word 0, bits 3:0 are the opcode, bits 7:4 the context type, bits 14:8 the function number, bits 43:24 the index and bit 63 the done request. All other bits are ignored.
- R2: A doorbell adds db_count to the pending work. The engine processes exactly that many instructions and then issues no further memory requests. After reset, mem_req and done_irq are 0.
- R3: The result is written at the result address. Word 0 holds the opcode in 3:0, the context type in 7:4, the completion code in 15:8 and the done request in bit 16, with bits 63:17 zero. Word 1 at +8 is written as zero.
- R4: Opcode 0 (no-op) completes with code 1 (good) whatever its target fields hold, and changes no context.
- R5: Code 2 (software error) is returned for the following: an opcode above 5, a context type above 5, a function number at or above LF_N, or an index at or above IDX_N. No context is changed.
- R6: Opcode 1 (init) reads a 64-bit word from result address + 128 into the entry. It marks the entry initialized and unlocked, and completes with code 1.
- R7: Opcode 2 (write) reads data from result address + 128 and a mask from + 256. It updates only the entry bits whose mask bit is 1 and completes with code 1. On an entry that was never initialized, it completes with code 4 and changes nothing.
- R8: Opcode 3 (read) writes the entry to result address + 128 and completes with code 1. On an uninitialized entry it completes with code 4 and leaves + 128 untouched.
- R9: Opcode 4 (lock) on a locked entry and opcode 5 (unlock) on an unlocked entry complete with code 5. Otherwise they set or clear the lock and complete with code 1. Both return code 4 on an uninitialized entry.
- R10: With cfg_big set, every word read or written is byte-reversed, and all field positions refer to the reversed word.
- R11: done_irq is a one-cycle pulse in the cycle after the last result write of an instruction whose done request was set. It never pulses otherwise.
- R12: A request holds mem_req, mem_we, mem_addr and mem_wdata stable until mem_gnt. Each read waits for its mem_rvalid before the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_base | input | AW | Ring base byte address, 16-byte aligned |
| cfg_size | input | SZ_W | Ring size in instructions |
| cfg_big | input | 1 | Byte-reverse all memory words |
| db_valid | input | 1 | Doorbell strobe |
| db_count | input | SZ_W | Number of newly posted instructions |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Byte address of the 64-bit word |
| mem_wdata | output | 64 | Write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read data |
| done_irq | output | 1 | Completion pulse for instructions asking for it |

## Verification
The time an instruction takes depends on the grant pattern, so the result words do not appear at a fixed cycle. They are complete once the final write of that instruction is granted. done_irq follows exactly one cycle after that grant. The bench therefore posts a batch, waits a bound longer than the worst-case duration of the batch under its one-in-three grant stall, and then inspects the result memory. It also compares the number of done pulses counted during the batch against the expected number. Request stability and the one-cycle shape of done_irq are timed per cycle by the bound checker. The bench also tracks request stability itself at every edge.

// File: rtl/ctx_aq_engine.sv
module ctx_aq_engine #(
  parameter int AW    = 32,
  parameter int LF_N  = 2,
  parameter int IDX_N = 2,
  parameter int SZ_W  = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   cfg_base,
  input  logic [SZ_W-1:0] cfg_size,
  input  logic            cfg_big,
  input  logic            db_valid,
  input  logic [SZ_W-1:0] db_count,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [63:0]     mem_wdata,
  input  logic            mem_gnt,
  input  logic            mem_rvalid,
  input  logic [63:0]     mem_rdata,
  output logic            done_irq
);
  localparam int NCT  = 6;
  localparam int NENT = NCT * LF_N * IDX_N;
  localparam int EW   = $clog2(NENT);
  localparam logic [7:0] C_GOOD = 8'd1, C_SWERR = 8'd2, C_FAULT = 8'd4, C_LOCK = 8'd5;

  typedef enum logic [3:0] {IDLE, RI0, WI0, RI1, WI1, RDAT, WDAT, RMSK, WMSK, EXEC, WR0, WR1, WCTX} st_t;

  function automatic logic [63:0] bswap(input logic [63:0] x);
    for (int i = 0; i < 8; i++) bswap[8*i +: 8] = x[8*(7-i) +: 8];
  endfunction

  st_t             st;
  logic [SZ_W-1:0] ptr;
  logic [SZ_W:0]   pend;
  logic [63:0]     w0, dat, msk;
  logic [AW-1:0]   ra;
  logic [7:0]      code, code_c;
  logic [63:0]     ctx [NENT];
  logic [NENT-1:0] vld, lck;

  wire [63:0] rd  = cfg_big ? bswap(mem_rdata) : mem_rdata;
  wire [3:0]  op  = w0[3:0];
  wire [3:0]  ct  = w0[7:4];
  wire [6:0]  lf  = w0[14:8];
  wire [19:0] ci  = w0[43:24];
  wire unused_rsv = ^{w0[23:15], w0[62:44]};
  wire in_rng = (int'(ct) < NCT) && (int'(lf) < LF_N) && (int'(ci) < IDX_N);
  wire [EW-1:0] ent = in_rng ? EW'((int'(ct) * LF_N + int'(lf)) * IDX_N + int'(ci)) : '0;
  wire rd_good = (op == 4'd3) && (code == C_GOOD);
  wire retire  = mem_gnt && ((st == WR1 && !rd_good) || st == WCTX);
  wire [SZ_W-1:0] nptr = ptr + 1'b1;

  always_comb begin
    if (op == 4'd0)                                        code_c = C_GOOD;
    else if (op > 4'd5 || !in_rng)                         code_c = C_SWERR;
    else if (op == 4'd1)                                   code_c = C_GOOD;
    else if (!vld[ent])                                    code_c = C_FAULT;
    else if ((op == 4'd4 && lck[ent]) || (op == 4'd5 && !lck[ent])) code_c = C_LOCK;
    else                                                   code_c = C_GOOD;
  end

  assign mem_req = st inside {RI0, RI1, RDAT, RMSK, WR0, WR1, WCTX};
  assign mem_we  = st inside {WR0, WR1, WCTX};

  always_comb begin
    case (st)
      RI0:     mem_addr = cfg_base + AW'({ptr, 4'h0});
      RI1:     mem_addr = cfg_base + AW'({ptr, 4'h8});
      RDAT:    mem_addr = ra + AW'(128);
      RMSK:    mem_addr = ra + AW'(256);
      WR1:     mem_addr = ra + AW'(8);
      WCTX:    mem_addr = ra + AW'(128);
      default: mem_addr = ra;
    endcase
  end

  logic [63:0] wraw;
  always_comb begin
    case (st)
      WR0:     wraw = {47'd0, w0[63], code, ct, op};
      WCTX:    wraw = ctx[ent];
      default: wraw = '0;
    endcase
  end
  assign mem_wdata = cfg_big ? bswap(wraw) : wraw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; ptr <= '0; pend <= '0; done_irq <= 1'b0;
      w0 <= '0; ra <= '0; dat <= '0; msk <= '0; code <= '0;
    end else begin
      pend     <= pend + (db_valid ? (SZ_W+1)'(db_count) : '0) - (retire ? 1'b1 : 1'b0);
      done_irq <= retire && w0[63];
      if (retire) ptr <= (nptr == cfg_size) ? '0 : nptr;
      case (st)
        IDLE: if (pend != 0) st <= RI0;
        RI0:  if (mem_gnt) st <= WI0;
        WI0:  if (mem_rvalid) begin w0 <= rd; st <= RI1; end
        RI1:  if (mem_gnt) st <= WI1;
        WI1:  if (mem_rvalid) begin
                ra   <= rd[AW-1:0];
                code <= code_c;
                st   <= (code_c == C_GOOD && (op == 4'd1 || op == 4'd2)) ? RDAT : EXEC;
              end
        RDAT: if (mem_gnt) st <= WDAT;
        WDAT: if (mem_rvalid) begin dat <= rd; st <= (op == 4'd2) ? RMSK : EXEC; end
        RMSK: if (mem_gnt) st <= WMSK;
        WMSK: if (mem_rvalid) begin msk <= rd; st <= EXEC; end
        EXEC: st <= WR0;
        WR0:  if (mem_gnt) st <= WR1;
        WR1:  if (mem_gnt) st <= rd_good ? WCTX : IDLE;
        WCTX: if (mem_gnt) st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end

  wire upd = (st == EXEC) && (code == C_GOOD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0; lck <= '0;
    end else if (upd) begin
      case (op)
        4'd1: begin vld[ent] <= 1'b1; lck[ent] <= 1'b0; end
        4'd4: lck[ent] <= 1'b1;
        4'd5: lck[ent] <= 1'b0;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (upd && op == 4'd1) ctx[ent] <= dat;
    if (upd && op == 4'd2) ctx[ent] <= (ctx[ent] & ~msk) | (dat & msk);
  end
endmodule

module ctx_aq_engine_chk #(
  parameter int AW   = 32,
  parameter int SZ_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mem_req,
  input logic            mem_we,
  input logic            mem_gnt,
  input logic            done_irq,
  input logic [AW-1:0]   mem_addr,
  input logic [63:0]     mem_wdata,
  input logic [SZ_W-1:0] cfg_size,
  input logic [SZ_W-1:0] ptr
);
  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq);
  assert_done_after_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> $past(mem_req && mem_we && mem_gnt));
  assert_ptr_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_size != 0) |-> (ptr < cfg_size));
endmodule

bind ctx_aq_engine ctx_aq_engine_chk #(.AW(AW), .SZ_W(SZ_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we), .mem_gnt(mem_gnt),
  .done_irq(done_irq), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .cfg_size(cfg_size), .ptr(ptr));

// File: tb/test_ctx_aq_engine.sv
`timescale 1ns/1ps
module test_ctx_aq_engine;
  localparam int RING = 5;
  localparam logic [31:0] BASE = 32'h100, RES = 32'h400;

  logic clk = 0, rst_n = 0, cfg_big = 0, db_valid = 0;
  logic [7:0] db_count = 0;
  logic mem_req, mem_we, mem_gnt, done_irq;
  logic mem_rvalid = 0;
  logic [63:0] mem_rdata = 0, mem_wdata;
  logic [31:0] mem_addr;
  logic [63:0] mem [512];
  logic tb_wr = 0;
  logic [31:0] tb_a = 0;
  logic [63:0] tb_d = 0;
  logic [1:0] gc = 0;
  int nchk = 0, nerr = 0, ndone = 0, viol = 0, wp = 0;
  logic prev_wait = 0;
  logic [31:0] prev_addr = 0;

  always #4 clk = ~clk;

  ctx_aq_engine #(.AW(32), .LF_N(2), .IDX_N(2), .SZ_W(8)) i_ctx_aq_engine (
    .clk(clk), .rst_n(rst_n), .cfg_base(BASE), .cfg_size(8'(RING)), .cfg_big(cfg_big),
    .db_valid(db_valid), .db_count(db_count), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .done_irq(done_irq));

  assign mem_gnt = (gc != 2'd2);

  always @(posedge clk) begin
    gc <= (gc == 2'd2) ? 2'd0 : gc + 2'd1;
    mem_rvalid <= 1'b0;
    if (tb_wr) mem[tb_a[11:3]] <= tb_d;
    else if (mem_req && mem_gnt) begin
      if (mem_we) mem[mem_addr[11:3]] <= mem_wdata;
      else begin mem_rvalid <= 1'b1; mem_rdata <= mem[mem_addr[11:3]]; end
    end
    if (done_irq) ndone <= ndone + 1;
    if (rst_n && prev_wait && (!mem_req || mem_addr != prev_addr)) viol <= viol + 1;
    prev_wait <= rst_n && mem_req && !mem_gnt;
    prev_addr <= mem_addr;
  end

  function automatic logic [63:0] rev(input logic [63:0] x);
    return {<<8{x}};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic mw(input logic [31:0] a, input logic [63:0] d);
    tb_wr = 1; tb_a = a; tb_d = cfg_big ? rev(d) : d;
    @(posedge clk); #2 tb_wr = 0;
  endtask

  function automatic logic [63:0] mr(input logic [31:0] a);
    return cfg_big ? rev(mem[a[11:3]]) : mem[a[11:3]];
  endfunction

  bit m_vld [7][3][3];
  bit m_lck [7][3][3];
  logic [63:0] m_dat [7][3][3];
  int seq [15] = '{3, 4, 1, 3, 2, 3, 4, 4, 2, 5, 5, 0, 6, 7, 3};

  function automatic int ecode(int op, int ct, int lf, int ci);
    if (op == 0) return 1;
    if (op > 5 || ct > 5 || lf > 1 || ci > 1) return 2;
    if (op == 1) return 1;
    if (!m_vld[ct][lf][ci]) return 4;
    if (op == 4 && m_lck[ct][lf][ci]) return 5;
    if (op == 5 && !m_lck[ct][lf][ci]) return 5;
    return 1;
  endfunction

  function automatic string optag(int op, int code);
    if (cfg_big) return "R10";
    if (op == 0) return "R4";
    if (code == 2) return "R5";
    if (op == 1) return "R6";
    if (op == 2) return "R7";
    if (op == 3) return "R8";
    return "R9";
  endfunction

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    wp = 0;
    for (int a = 0; a < 7; a++) for (int b = 0; b < 3; b++) for (int c = 0; c < 3; c++) begin
      m_vld[a][b][c] = 0; m_lck[a][b][c] = 0; m_dat[a][b][c] = '0;
    end
    @(posedge clk); #2;
    chk("R2 req after reset", {63'd0, mem_req}, 64'd0);
    chk("R11 done after reset", {63'd0, done_irq}, 64'd0);
  endtask

  task automatic run_target(input int ct, input int lf, input int ci);
    for (int b = 0; b < 3; b++) begin
      logic [63:0] ew0 [5];
      logic [63:0] e128 [5];
      string tg [5];
      int nexp = 0, d0;
      for (int k = 0; k < 5; k++) begin
        int s = b * 5 + k;
        int op = seq[s];
        int code = ecode(op, ct, lf, ci);
        logic [31:0] ra = RES + 32'(k) * 32'h200;
        logic [63:0] dv = 64'h0123_4567_89AB_CDEF ^ (64'(ct * 9 + lf * 3 + ci) << 40) ^ (64'(s) * 64'h1111_0000_0101);
        logic [63:0] mk = 64'hF0F0_FF00_00FF_3C3C ^ (64'(s) << 8);
        logic [63:0] w0 = 64'(op) | (64'(ct) << 4) | (64'(lf) << 8) | (64'(ci) << 24)
                          | (64'(s & 1) << 63) | (64'(s & 2) << 19);
        ew0[k]  = {47'd0, 1'(s & 1), 8'(code), 4'(ct), 4'(op)};
        tg[k]   = optag(op, code);
        e128[k] = (op == 3 && code == 1) ? m_dat[ct][lf][ci] : dv;
        nexp   += s & 1;
        if (code == 1 && op == 1) begin m_vld[ct][lf][ci] = 1; m_lck[ct][lf][ci] = 0; m_dat[ct][lf][ci] = dv; end
        if (code == 1 && op == 2) m_dat[ct][lf][ci] = (m_dat[ct][lf][ci] & ~mk) | (dv & mk);
        if (code == 1 && op == 4) m_lck[ct][lf][ci] = 1;
        if (code == 1 && op == 5) m_lck[ct][lf][ci] = 0;
        mw(BASE + 32'(wp) * 16, w0);
        mw(BASE + 32'(wp) * 16 + 8, 64'(ra));
        mw(ra, 64'hFFFF_FFFF_FFFF_FFFF);
        mw(ra + 8, 64'hFFFF_FFFF_FFFF_FFFF);
        mw(ra + 128, dv);
        mw(ra + 256, mk);
        wp = (wp + 1) % RING;
      end
      d0 = ndone;
      db_valid = 1; db_count = 8'd5;
      @(posedge clk); #2 db_valid = 0;
      repeat (330) @(posedge clk);
      #2;
      for (int k = 0; k < 5; k++) begin
        logic [31:0] ra = RES + 32'(k) * 32'h200;
        chk(cfg_big ? "R10 order" : "R1 fetch order", {56'd0, mr(ra)[7:0]}, {56'd0, ew0[k][7:0]});
        chk(tg[k], mr(ra), ew0[k]);
        chk(cfg_big ? "R10 word1" : "R3 word1", mr(ra + 8), 64'd0);
        chk(cfg_big ? "R10 ctx" : "R8 ctx area", mr(ra + 128), e128[k]);
      end
      chk("R11 done count", 64'(ndone - d0), 64'(nexp));
      chk("R2 idle", {63'd0, mem_req}, 64'd0);
    end
  endtask

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = '0;
    for (int be = 0; be < 2; be++) begin
      cfg_big = 1'(be);
      do_reset();
      if (be == 0) begin
        for (int ct = 0; ct < 7; ct++) for (int lf = 0; lf < 3; lf++) for (int ci = 0; ci < 3; ci++)
          run_target(ct, lf, ci);
        run_target(0, 0, 0);
      end else begin
        for (int ct = 0; ct < 3; ct++) for (int lf = 0; lf < 2; lf++) for (int ci = 0; ci < 2; ci++)
          run_target(ct, lf, ci);
      end
    end
    chk("R12 request stability", 64'(viol), 64'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL R2 watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    $finish;
  end
endmodule